// File: doc/BRIEF.md
# AHB-Lite Burst Address Sequencer

This block drives the address phase of an AHB-Lite manager. A burst request carries a start address, a transfer size, a burst type and a direction. The sequencer turns it into one address-phase beat per bus cycle on `haddr`, `htrans`, `hsize`, `hburst` and `hwrite`. Each beat advances only when `hready` is high. When `hready` is low, everything already on the bus stays where it is.

The sequencer handles single transfers, fixed incrementing bursts, fixed wrapping bursts and incrementing bursts of undefined length. The fixed bursts come in lengths of 4, 8 and 16 beats.

The manager can raise `mgrBusy` to insert BUSY cycles inside a burst, and the burst carries on afterwards. Some requests would break a bus rule: a fixed incrementing burst that runs past a 1 KB boundary, or a size wider than the data bus. Such a request never reaches the bus. Instead, a one-cycle error flag is raised.

Top module: `ahb_burst_seq`

## Requirements
- R1: After reset, `htrans` is IDLE (2'b00), `haddr` is 0 and `reqErr` is 0. Outside a burst, `htrans` stays IDLE.
- R2: Transfer kinds are encoded IDLE=00, BUSY=01, NONSEQ=10 and SEQ=11. The first beat of a request is NONSEQ and every later beat is SEQ.
- R2 (beat count): The burst type sets how many beats are issued. The codes are 000 single (1 beat), 011 and 010 for 4 beats, 101 and 100 for 8 beats, and 111 and 110 for 16 beats. The odd codes increment and the even codes wrap.
- R3: In an incrementing burst, each SEQ address is the previous address plus 2^size bytes. Size codes 0, 1 and 2 mean byte, halfword and word.
- R4: In a wrapping burst, addresses increment by 2^size. They wrap inside an aligned block whose size is the beat count times 2^size bytes. For example, WRAP4 of words from 0x34 gives 0x34, 0x38, 0x3C, 0x30.
- R5: `hsize`, `hburst` and `hwrite` equal the request's values and stay constant on every beat of the burst.
- R6: While `hready` is low, all address-phase outputs hold their values. A request seen while idle is not started until `hready` is high.
- R7: If `mgrBusy` is high when a beat is accepted and more beats remain, the next cycle is BUSY and already shows the next address. The burst resumes with SEQ at that same address once `mgrBusy` is low.
- R8: A request is rejected if it is a fixed incrementing burst and the low 10 address bits plus its total byte span exceed 1024. For a rejected request, `reqErr` is 1 in the following cycle and `htrans` stays IDLE. A burst that ends exactly at a 1 KB boundary is accepted.
- R9: A request whose size code exceeds log2 of the bus width in bytes (code 3 or more for a 32-bit bus) is rejected in the same way as in R8.
- R10: An undefined-length burst (code 001) keeps issuing beats while `reqValid` is high. When a beat is accepted with `reqValid` low, the next cycle is IDLE.
- R11: When an undefined-length burst's next address would start a new 1 KB block, that beat is issued as NONSEQ instead of SEQ, so no SEQ beat of an incrementing burst falls on a 1 KB-aligned address.
- R12: After the last beat of a fixed burst is accepted, the next cycle is IDLE, so consecutive bursts are separated by at least one IDLE cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Burst request; held for the life of an undefined-length burst |
| reqAddr | input | ADDR_W | Start address, aligned to the transfer size |
| reqSize | input | 3 | Transfer size code, bytes = 2^code |
| reqBurst | input | 3 | Burst type code |
| reqWrite | input | 1 | 1 = write, 0 = read |
| mgrBusy | input | 1 | Manager not ready for the next beat; inserts BUSY |
| hready | input | 1 | Bus ready; low holds the address phase |
| haddr | output | ADDR_W | Beat address |
| htrans | output | 2 | Transfer kind |
| hsize | output | 3 | Transfer size of the current burst |
| hburst | output | 3 | Burst type of the current burst |
| hwrite | output | 1 | Direction of the current burst |
| reqErr | output | 1 | One-cycle flag that a request was rejected |

## Verification
The bench builds the block with its defaults: a 32-bit address and data bus and a 1 KB boundary. These bring size code 3 within reach as an oversized request, and they let a 16-beat word wrap fill a full 64-byte block near the top of a 1 KB page. Each burst type is checked from a vector table at addresses chosen to exercise the wrap point. Directed tests then cover:
- a fixed burst ending exactly on the 1 KB boundary and one crossing it by one word;
- wait states both before the start and in mid-burst;
- a BUSY insertion;
- an undefined-length burst that runs into a 1 KB boundary and is then ended by dropping the request.

// File: rtl/ahb_burst_seq_pkg.sv
package ahb_burst_seq_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } transKind_e;

  localparam logic [2:0] BURST_SINGLE = 3'b000;
  localparam logic [2:0] BURST_UNDEF  = 3'b001;

  // Control-to-datapath strobes
  typedef struct packed {
    logic loadReq;   // capture a new request
    logic stepAddr;  // move to the next beat address
  } seqStrobe_t;

  // Beat count of a burst code (undefined-length and single report 1)
  function automatic logic [4:0] beatsOf(input logic [2:0] code);
    case (code[2:1])
      2'b01:   beatsOf = 5'd4;
      2'b10:   beatsOf = 5'd8;
      2'b11:   beatsOf = 5'd16;
      default: beatsOf = 5'd1;
    endcase
  endfunction

  function automatic logic isWrap(input logic [2:0] code);
    isWrap = (code[0] == 1'b0) && (code[2:1] != 2'b00);
  endfunction

  function automatic logic isFixedIncr(input logic [2:0] code);
    isFixedIncr = (code[0] == 1'b1) && (code[2:1] != 2'b00);
  endfunction

endpackage

// File: rtl/ahb_burst_seq_dpath.sv
module ahb_burst_seq_dpath
  import ahb_burst_seq_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int KB_LOG2 = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [2:0]        reqSize,
  input  logic [2:0]        reqBurst,
  input  logic              reqWrite,
  output logic [ADDR_W-1:0] haddr,
  output logic [2:0]        hsize,
  output logic [2:0]        hburst,
  output logic              hwrite,
  output logic              reqBad,
  output logic              nextCrossKb
);

  localparam int MAX_SIZE = $clog2(DATA_W / 8);
  localparam int SPAN_W   = KB_LOG2 + 9;
  localparam logic [SPAN_W-1:0] KB_BYTES = SPAN_W'(1) << KB_LOG2;

  logic [ADDR_W-1:0] haddrQ;
  logic [2:0]        hsizeQ;
  logic [2:0]        hburstQ;
  logic              hwriteQ;

  // Request legality
  logic [SPAN_W-1:0] reqSpan;
  logic [SPAN_W-1:0] reqEnd;
  logic              sizeBad;
  logic              crossBad;

  always_comb begin
    reqSpan  = SPAN_W'(beatsOf(reqBurst)) << reqSize;
    reqEnd   = SPAN_W'(reqAddr[KB_LOG2-1:0]) + reqSpan;
    sizeBad  = (reqSize > 3'(MAX_SIZE));
    crossBad = isFixedIncr(reqBurst) && (reqEnd > KB_BYTES);
    reqBad   = sizeBad || crossBad;
  end

  // Next beat address
  logic [ADDR_W-1:0] stepBytes;
  logic [ADDR_W-1:0] incrAddr;
  logic [ADDR_W-1:0] wrapMask;
  logic [ADDR_W-1:0] wrapAddr;
  logic [ADDR_W-1:0] nextAddr;

  always_comb begin
    stepBytes   = ADDR_W'(1) << hsizeQ;
    incrAddr    = haddrQ + stepBytes;
    wrapMask    = (ADDR_W'(beatsOf(hburstQ)) << hsizeQ) - ADDR_W'(1);
    wrapAddr    = (haddrQ & ~wrapMask) | (incrAddr & wrapMask);
    nextAddr    = isWrap(hburstQ) ? wrapAddr : incrAddr;
    nextCrossKb = (incrAddr[KB_LOG2-1:0] == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haddrQ  <= '0;
      hsizeQ  <= '0;
      hburstQ <= BURST_SINGLE;
      hwriteQ <= 1'b0;
    end else if (strobe.loadReq) begin
      haddrQ  <= reqAddr;
      hsizeQ  <= reqSize;
      hburstQ <= reqBurst;
      hwriteQ <= reqWrite;
    end else if (strobe.stepAddr) begin
      haddrQ  <= nextAddr;
    end
  end

  assign haddr  = haddrQ;
  assign hsize  = hsizeQ;
  assign hburst = hburstQ;
  assign hwrite = hwriteQ;

endmodule

// File: rtl/ahb_burst_seq_ctrl.sv
module ahb_burst_seq_ctrl
  import ahb_burst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hready,
  input  logic       reqValid,
  input  logic       mgrBusy,
  input  logic [2:0] reqBurst,
  input  logic [2:0] curBurst,
  input  logic       reqBad,
  input  logic       nextCrossKb,
  output seqStrobe_t strobe,
  output logic [1:0] htrans,
  output logic       reqErr
);

  transKind_e transQ, transD;
  logic [4:0] beatsLeftQ, beatsLeftD;
  logic       errQ, errD;
  logic       undefLen;
  logic       lastBeat;

  always_comb begin
    undefLen = (curBurst == BURST_UNDEF);
    lastBeat = undefLen ? !reqValid : (beatsLeftQ == 5'd0);
  end

  always_comb begin
    transD     = transQ;
    beatsLeftD = beatsLeftQ;
    errD       = 1'b0;
    strobe     = '0;
    if (hready) begin
      unique case (transQ)
        TR_IDLE: begin
          if (reqValid) begin
            if (reqBad) begin
              errD = 1'b1;
            end else begin
              strobe.loadReq = 1'b1;
              transD         = TR_NONSEQ;
              beatsLeftD     = beatsOf(reqBurst) - 5'd1;
            end
          end
        end
        TR_NONSEQ, TR_SEQ: begin
          if (lastBeat) begin
            transD = TR_IDLE;
          end else begin
            strobe.stepAddr = 1'b1;
            if (!undefLen) beatsLeftD = beatsLeftQ - 5'd1;
            if (undefLen && nextCrossKb) transD = TR_NONSEQ;
            else if (mgrBusy)            transD = TR_BUSY;
            else                         transD = TR_SEQ;
          end
        end
        TR_BUSY: begin
          if (undefLen && !reqValid) transD = TR_IDLE;
          else if (mgrBusy)          transD = TR_BUSY;
          else                       transD = TR_SEQ;
        end
        default: transD = TR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      transQ     <= TR_IDLE;
      beatsLeftQ <= '0;
      errQ       <= 1'b0;
    end else begin
      transQ     <= transD;
      beatsLeftQ <= beatsLeftD;
      errQ       <= errD;
    end
  end

  assign htrans = transQ;
  assign reqErr = errQ;

endmodule

// File: rtl/ahb_burst_seq.sv
module ahb_burst_seq
  import ahb_burst_seq_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int KB_LOG2 = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [2:0]        reqSize,
  input  logic [2:0]        reqBurst,
  input  logic              reqWrite,
  input  logic              mgrBusy,
  input  logic              hready,
  output logic [ADDR_W-1:0] haddr,
  output logic [1:0]        htrans,
  output logic [2:0]        hsize,
  output logic [2:0]        hburst,
  output logic              hwrite,
  output logic              reqErr
);

  seqStrobe_t strobe;
  logic       reqBad;
  logic       nextCrossKb;

  ahb_burst_seq_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .hready      (hready),
    .reqValid    (reqValid),
    .mgrBusy     (mgrBusy),
    .reqBurst    (reqBurst),
    .curBurst    (hburst),
    .reqBad      (reqBad),
    .nextCrossKb (nextCrossKb),
    .strobe      (strobe),
    .htrans      (htrans),
    .reqErr      (reqErr)
  );

  ahb_burst_seq_dpath #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .KB_LOG2 (KB_LOG2)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqAddr     (reqAddr),
    .reqSize     (reqSize),
    .reqBurst    (reqBurst),
    .reqWrite    (reqWrite),
    .haddr       (haddr),
    .hsize       (hsize),
    .hburst      (hburst),
    .hwrite      (hwrite),
    .reqBad      (reqBad),
    .nextCrossKb (nextCrossKb)
  );

endmodule

// File: rtl/ahb_burst_seq_chk.sv
module ahb_burst_seq_chk #(
  parameter int ADDR_W  = 32,
  parameter int KB_LOG2 = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              hready,
  input logic [ADDR_W-1:0] haddr,
  input logic [1:0]        htrans,
  input logic [2:0]        hsize,
  input logic [2:0]        hburst,
  input logic              hwrite,
  input logic              reqErr
);

  // R6
  hold_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hready |=> ($stable(haddr) && $stable(htrans) && $stable(hsize)
                 && $stable(hburst) && $stable(hwrite)));

  // R3
  incr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (htrans == 2'b11 && hburst[0] && $past(hready)
     && ($past(htrans) == 2'b11 || $past(htrans) == 2'b10))
    |-> haddr == $past(haddr) + (ADDR_W'(1) << hsize));

  // R5
  ctrl_const_chk: assert property (@(posedge clk) disable iff (!rstN)
    (htrans == 2'b11 || htrans == 2'b01)
    |-> ($stable(hsize) && $stable(hburst) && $stable(hwrite)));

  // R7
  busy_inside_chk: assert property (@(posedge clk) disable iff (!rstN)
    (htrans == 2'b01) |-> $past(htrans) != 2'b00);

  // R8
  err_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqErr |-> htrans == 2'b00);

  // R11
  kb_seq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (htrans == 2'b11 && hburst[0]) |-> haddr[KB_LOG2-1:0] != '0);

endmodule

bind ahb_burst_seq ahb_burst_seq_chk #(
  .ADDR_W  (ADDR_W),
  .KB_LOG2 (KB_LOG2)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .hready (hready),
  .haddr  (haddr),
  .htrans (htrans),
  .hsize  (hsize),
  .hburst (hburst),
  .hwrite (hwrite),
  .reqErr (reqErr)
);

// File: tb/ahb_burst_seq_bench.sv
module ahb_burst_seq_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqWrite, mgrBusy, hready;
  logic [31:0] reqAddr;
  logic [2:0]  reqSize, reqBurst;
  logic [31:0] haddr;
  logic [1:0]  htrans;
  logic [2:0]  hsize, hburst;
  logic        hwrite, reqErr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ahb_burst_seq u_ahb_burst_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqBurst(reqBurst), .reqWrite(reqWrite),
    .mgrBusy(mgrBusy), .hready(hready), .haddr(haddr), .htrans(htrans),
    .hsize(hsize), .hburst(hburst), .hwrite(hwrite), .reqErr(reqErr)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [2:0]  size;
    logic [2:0]  burst;
    logic        wr;
    logic [4:0]  beats;
    logic [31:0] second;
    logic [31:0] last;
  } vec_t;

  // start, size, burst, write, beats, second address, last address
  localparam vec_t VECS [7] = '{
    '{32'h34,   3'd2, 3'b010, 1'b1, 5'd4,  32'h38,  32'h30},   // R4 WRAP4 word
    '{32'h100,  3'd2, 3'b011, 1'b0, 5'd4,  32'h104, 32'h10C},  // R3 INCR4 word
    '{32'h2A,   3'd1, 3'b100, 1'b1, 5'd8,  32'h2C,  32'h28},   // R4 WRAP8 half
    '{32'h200,  3'd0, 3'b111, 1'b0, 5'd16, 32'h201, 32'h20F},  // R3 INCR16 byte
    '{32'h3C8,  3'd2, 3'b110, 1'b1, 5'd16, 32'h3CC, 32'h3C4},  // R4 WRAP16 word
    '{32'h5000, 3'd2, 3'b000, 1'b1, 5'd1,  32'h5000, 32'h5000},// R2 single
    '{32'h3E0,  3'd2, 3'b101, 1'b0, 5'd8,  32'h3E4, 32'h3FC}   // R8 ends on 1KB edge
  };

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic drive(input logic [31:0] a, input logic [2:0] s,
                       input logic [2:0] b, input logic w);
    reqAddr = a; reqSize = s; reqBurst = b; reqWrite = w; reqValid = 1'b1;
  endtask

  task automatic runBurst(input vec_t v);
    int beats = 0;
    logic [31:0] second = '0;
    logic [31:0] last = '0;
    bit done = 0;
    @(negedge clk);
    drive(v.addr, v.size, v.burst, v.wr);
    for (int c = 0; c < 40 && !done; c++) begin
      @(negedge clk);
      reqValid = 1'b0;
      if (htrans == 2'b10 || htrans == 2'b11) begin
        beats++;
        chk(htrans == ((beats == 1) ? 2'b10 : 2'b11), "R2 beat kind",
            32'(htrans), (beats == 1) ? 32'h2 : 32'h3);
        chk(hsize == v.size && hburst == v.burst && hwrite == v.wr,
            "R5 control held", {25'd0, hsize, hburst, hwrite},
            {25'd0, v.size, v.burst, v.wr});
        if (beats == 2) second = haddr;
        last = haddr;
      end else if (beats > 0) begin
        chk(htrans == 2'b00, "R12 idle after burst", 32'(htrans), 32'h0);
        done = 1;
      end
    end
    chk(beats == int'(v.beats), "R2 beat count", 32'(beats), 32'(v.beats));
    if (v.beats > 1)
      chk(second == v.second, v.burst[0] ? "R3 second addr" : "R4 second addr",
          second, v.second);
    chk(last == v.last, v.burst[0] ? "R3 last addr" : "R4 last addr", last, v.last);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; mgrBusy = 1'b0;
    hready = 1'b1; reqAddr = '0; reqSize = '0; reqBurst = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(htrans == 2'b00, "R1 reset htrans", 32'(htrans), 32'h0);
    chk(haddr == 32'h0, "R1 reset haddr", haddr, 32'h0);
    chk(reqErr == 1'b0, "R1 reset reqErr", 32'(reqErr), 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk(htrans == 2'b00, "R1 idle without request", 32'(htrans), 32'h0);

    foreach (VECS[i]) runBurst(VECS[i]);

    // R8 crossing by one word is rejected
    @(negedge clk);
    drive(32'h3E4, 3'd2, 3'b101, 1'b0);
    @(negedge clk);
    chk(reqErr == 1'b1, "R8 reject flag", 32'(reqErr), 32'h1);
    chk(htrans == 2'b00, "R8 stays idle", 32'(htrans), 32'h0);
    reqValid = 1'b0;
    @(negedge clk);
    chk(reqErr == 1'b0, "R8 flag one cycle", 32'(reqErr), 32'h0);

    // R9 oversized transfer rejected
    drive(32'h0, 3'd3, 3'b000, 1'b1);
    @(negedge clk);
    chk(reqErr == 1'b1, "R9 reject flag", 32'(reqErr), 32'h1);
    chk(htrans == 2'b00, "R9 stays idle", 32'(htrans), 32'h0);
    reqValid = 1'b0;
    @(negedge clk);

    // R6 wait states: blocked start, then held mid-burst
    hready = 1'b0;
    drive(32'h40, 3'd2, 3'b011, 1'b1);
    @(negedge clk);
    chk(htrans == 2'b00, "R6 no start while not ready", 32'(htrans), 32'h0);
    hready = 1'b1;
    @(negedge clk);
    chk(htrans == 2'b10 && haddr == 32'h40, "R6 start", haddr, 32'h40);
    reqValid = 1'b0;
    @(negedge clk);
    chk(htrans == 2'b11 && haddr == 32'h44, "R6 second beat", haddr, 32'h44);
    hready = 1'b0;
    @(negedge clk);
    chk(htrans == 2'b11 && haddr == 32'h44, "R6 held addr", haddr, 32'h44);
    chk(hsize == 3'd2 && hwrite == 1'b1, "R6 held control",
        {28'd0, hsize, hwrite}, {28'd0, 3'd2, 1'b1});
    hready = 1'b1;
    @(negedge clk);
    chk(haddr == 32'h48, "R6 resumes", haddr, 32'h48);
    @(negedge clk);
    @(negedge clk);
    chk(htrans == 2'b00, "R12 idle after waited burst", 32'(htrans), 32'h0);

    // R7 BUSY insertion
    drive(32'h80, 3'd2, 3'b011, 1'b0);
    @(negedge clk);
    chk(htrans == 2'b10 && haddr == 32'h80, "R7 first beat", haddr, 32'h80);
    reqValid = 1'b0; mgrBusy = 1'b1;
    @(negedge clk);
    chk(htrans == 2'b01, "R7 busy kind", 32'(htrans), 32'h1);
    chk(haddr == 32'h84, "R7 busy shows next addr", haddr, 32'h84);
    mgrBusy = 1'b0;
    @(negedge clk);
    chk(htrans == 2'b11 && haddr == 32'h84, "R7 resumes SEQ", haddr, 32'h84);
    @(negedge clk);
    chk(haddr == 32'h88, "R7 third beat", haddr, 32'h88);
    @(negedge clk);
    chk(haddr == 32'h8C, "R7 fourth beat", haddr, 32'h8C);
    @(negedge clk);
    chk(htrans == 2'b00, "R7 four beats then idle", 32'(htrans), 32'h0);

    // R10 R11 undefined length across a 1KB boundary
    drive(32'h3F8, 3'd2, 3'b001, 1'b1);
    @(negedge clk);
    chk(htrans == 2'b10 && haddr == 32'h3F8, "R10 first beat", haddr, 32'h3F8);
    @(negedge clk);
    chk(htrans == 2'b11 && haddr == 32'h3FC, "R10 continues", haddr, 32'h3FC);
    @(negedge clk);
    chk(htrans == 2'b10, "R11 restart kind", 32'(htrans), 32'h2);
    chk(haddr == 32'h400, "R11 restart addr", haddr, 32'h400);
    reqValid = 1'b0;
    @(negedge clk);
    chk(htrans == 2'b00, "R10 ends on drop", 32'(htrans), 32'h0);

    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule